// File: doc/BRIEF.md
# I2C Control and Data-Buffer Slice

This block is the register-facing slice of an I2C master/slave controller. It holds the single byte that moves between the processor and the serial byte engine, and it keeps an empty flag for that byte. It also holds a small set of control bits: a transmit-interrupt enable, a request to answer the next received byte with a Not-Acknowledge, and a one-shot flush command.

The processor side is a plain synchronous write port with a combinational read path. Address 0 is the data byte. Address 1 is the control register. Address 2 is the status register. The engine side tells the slice when a byte has been taken for transmission, when a received byte is ready, when a Not-Acknowledge has gone out, and whether the controller is enabled. From this state the slice drives the interrupt request, the byte to transmit and the "NAK next byte" command.

The reset input is asserted asynchronously and released synchronously. All internal state sees reset end two clock edges after `rst_n` rises.

Top module: `i2c_ctl_buf`

## Requirements
- R1: After reset, the data byte reads 0, the empty flag is 1, the interrupt-enable bit (control bit 3) and the NAK request (control bit 2) are 0, `irq` is 0 and `nak_next` is 0.
- R2: A write to address 0 loads the byte into the data register and clears the empty flag. From the next cycle the byte appears on `tx_byte` and at read address 0. The empty flag reads at address 2, bit 0, and every other status bit reads 0. Address 3 reads 0.
- R3: A pulse on `eng_tx_taken` sets the empty flag on the next cycle. A write to address 0 in the same cycle takes precedence and leaves the flag cleared.
- R4: A pulse on `eng_rx_valid` loads `eng_rx_byte` into the data register and leaves the empty flag unchanged. A same-cycle write to address 0 takes precedence over the received byte.
- R5: `irq` is 1 exactly when the interrupt-enable bit (control bit 3, written through address 1) is 1 and the empty flag is 1.
- R6: Writing control bit 2 as 1 sets the NAK request. The request is shown on `nak_next` and reads back at address 1, bit 2.
- R7: While the NAK request is 1, a control write with bit 2 at 0 leaves it at 1.
- R8: The NAK request goes to 0 on the cycle after `eng_nak_sent` is 1, and it is held at 0 while `eng_enable` is 0. Both conditions win over a same-cycle write that sets it.
- R9: A control write with bit 1 set flushes the buffer: the data register becomes 0 and the empty flag becomes 1. Bit 1 of address 1 always reads 0.
- R10: A flush wins over a same-cycle `eng_rx_valid` and over a same-cycle `eng_tx_taken`. The data register ends at 0 and the flag at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| cpu_wr | input | 1 | Write strobe for one cycle |
| cpu_addr | input | 2 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for `cpu_addr` (combinational) |
| eng_tx_taken | input | 1 | The engine has taken the buffered byte for transmission |
| eng_rx_valid | input | 1 | The engine has a received byte ready |
| eng_rx_byte | input | 8 | The received byte |
| eng_nak_sent | input | 1 | The engine has sent a Not-Acknowledge |
| eng_enable | input | 1 | Controller enable state |
| tx_byte | output | 8 | Byte held for transmission |
| tx_empty | output | 1 | Empty flag |
| irq | output | 1 | Transmit interrupt request |
| nak_next | output | 1 | Command to answer the next received byte with a NAK |

## Verification
The assertions assume that the engine strobes are single-cycle pulses sampled on the rising edge. They also assume that `eng_enable` holds a defined level whenever reset is inactive, since its low level alone forces the NAK request off. The random stimulus drives every input at the falling edge to a defined value. It keeps `eng_enable` mostly high so that a NAK request can survive long enough for the sticky-write case to occur. Directed sequences cover every collision that the priority rules settle: flush against a received byte, a data write against a taken byte, and a set request against an engine clear.

// File: rtl/i2c_ctl_buf_pkg.sv
package i2c_ctl_buf_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA   = 2'd0,
    REG_CTRL   = 2'd1,
    REG_STATUS = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;

  // control register bit positions
  localparam int unsigned CTL_TXIE  = 3;
  localparam int unsigned CTL_NAK   = 2;
  localparam int unsigned CTL_FLUSH = 1;
  // status register bit positions
  localparam int unsigned STS_EMPTY = 0;
endpackage

// File: rtl/i2c_ctl_buf_rst.sv
module i2c_ctl_buf_rst #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/i2c_ctl_buf_data.sv
module i2c_ctl_buf_data #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              cpu_load,
  input  logic [DATA_W-1:0] cpu_byte,
  input  logic              rx_load,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              tx_take,
  output logic [DATA_W-1:0] data_q,
  output logic              empty_q
);
  logic [DATA_W-1:0] data_d;
  logic              empty_d;
  logic              data_en;
  logic              empty_en;

  always_comb begin
    data_d   = data_q;
    empty_d  = empty_q;
    data_en  = flush | cpu_load | rx_load;
    empty_en = flush | cpu_load | tx_take;
    if (flush) begin
      data_d  = '0;
      empty_d = 1'b1;
    end else if (cpu_load) begin
      data_d  = cpu_byte;
      empty_d = 1'b0;
    end else begin
      if (rx_load) data_d  = rx_byte;
      if (tx_take) empty_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else begin
      if (data_en)  data_q  <= data_d;
      if (empty_en) empty_q <= empty_d;
    end
  end

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty_q && data_q == '0));
  a_r2_load_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_load && !flush) |=> (!empty_q && data_q == $past(cpu_byte)));
  a_r3_take_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && !cpu_load && !flush) |=> empty_q);
  a_r4_rx_keeps_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && !cpu_load && !flush && !tx_take) |=> $stable(empty_q));
endmodule

// File: rtl/i2c_ctl_buf_ctrl.sv
module i2c_ctl_buf_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic wr_txie,
  input  logic wr_nak,
  input  logic nak_sent,
  input  logic enable,
  output logic txie_q,
  output logic nak_q
);
  logic txie_d, nak_d;
  logic nak_clr;

  always_comb begin
    nak_clr = nak_sent | ~enable;
    txie_d  = ctrl_wr ? wr_txie : txie_q;
    nak_d   = nak_q;
    if (nak_clr)                nak_d = 1'b0;
    else if (ctrl_wr && wr_nak) nak_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txie_q <= 1'b0;
      nak_q  <= 1'b0;
    end else begin
      txie_q <= txie_d;
      nak_q  <= nak_d;
    end
  end

  a_r6_nak_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_nak && enable && !nak_sent) |=> nak_q);
  a_r7_nak_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (nak_q && enable && !nak_sent) |=> nak_q);
  a_r8_nak_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
    (nak_sent || !enable) |=> !nak_q);
endmodule

// File: rtl/i2c_ctl_buf.sv
module i2c_ctl_buf
  import i2c_ctl_buf_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned RST_SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              eng_tx_taken,
  input  logic              eng_rx_valid,
  input  logic [DATA_W-1:0] eng_rx_byte,
  input  logic              eng_nak_sent,
  input  logic              eng_enable,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_empty,
  output logic              irq,
  output logic              nak_next
);
  logic     srst_n;
  logic     wr_data, wr_ctrl, flush;
  logic     txie_q, nak_q;
  reg_sel_e sel;

  i2c_ctl_buf_rst #(.STAGES(RST_SYNC)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(srst_n)
  );

  always_comb begin
    sel     = reg_sel_e'(cpu_addr);
    wr_data = cpu_wr && (sel == REG_DATA);
    wr_ctrl = cpu_wr && (sel == REG_CTRL);
    flush   = wr_ctrl && cpu_wdata[CTL_FLUSH];
  end

  i2c_ctl_buf_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rst_n(srst_n), .flush(flush),
    .cpu_load(wr_data), .cpu_byte(cpu_wdata),
    .rx_load(eng_rx_valid), .rx_byte(eng_rx_byte),
    .tx_take(eng_tx_taken), .data_q(tx_byte), .empty_q(tx_empty)
  );

  i2c_ctl_buf_ctrl u_ctrl (
    .clk(clk), .rst_n(srst_n), .ctrl_wr(wr_ctrl),
    .wr_txie(cpu_wdata[CTL_TXIE]), .wr_nak(cpu_wdata[CTL_NAK]),
    .nak_sent(eng_nak_sent), .enable(eng_enable),
    .txie_q(txie_q), .nak_q(nak_q)
  );

  assign irq      = txie_q & tx_empty;
  assign nak_next = nak_q;

  always_comb begin
    cpu_rdata = '0;
    unique case (sel)
      REG_DATA:   cpu_rdata = tx_byte;
      REG_CTRL: begin
        cpu_rdata[CTL_TXIE] = txie_q;
        cpu_rdata[CTL_NAK]  = nak_q;
      end
      REG_STATUS: cpu_rdata[STS_EMPTY] = tx_empty;
      default:    cpu_rdata = '0;
    endcase
  end

  a_r5_irq_needs_empty: assert property (@(posedge clk) disable iff (!srst_n)
    irq |-> tx_empty);
  a_r10_flush_beats_engine: assert property (@(posedge clk) disable iff (!srst_n)
    (flush && (eng_rx_valid || eng_tx_taken)) |=> (tx_empty && tx_byte == '0));
endmodule

// File: tb/test_i2c_ctl_buf.sv
module test_i2c_ctl_buf;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_wr;
  logic [1:0]    cpu_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata;
  logic          eng_tx_taken, eng_rx_valid, eng_nak_sent, eng_enable;
  logic [DW-1:0] eng_rx_byte, tx_byte;
  logic          tx_empty, irq, nak_next;

  int n_run = 0;
  int n_fail = 0;

  logic [DW-1:0] m_data;
  logic          m_empty, m_txie, m_nak;

  always #4 clk = ~clk;

  i2c_ctl_buf i_i2c_ctl_buf (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .eng_tx_taken(eng_tx_taken), .eng_rx_valid(eng_rx_valid),
    .eng_rx_byte(eng_rx_byte), .eng_nak_sent(eng_nak_sent),
    .eng_enable(eng_enable), .tx_byte(tx_byte), .tx_empty(tx_empty),
    .irq(irq), .nak_next(nak_next)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(logic [1:0] a);
    case (a)
      2'd0:    return m_data;
      2'd1:    return {4'b0, m_txie, m_nak, 2'b00};
      2'd2:    return {7'b0, m_empty};
      default: return '0;
    endcase
  endfunction

  task automatic model_step();
    logic fl, dw, cw;
    cw = cpu_wr && cpu_addr == 2'd1;
    dw = cpu_wr && cpu_addr == 2'd0;
    fl = cw && cpu_wdata[1];
    if (fl)                m_data = '0;
    else if (dw)           m_data = cpu_wdata;
    else if (eng_rx_valid) m_data = eng_rx_byte;
    if (fl)                m_empty = 1'b1;
    else if (dw)           m_empty = 1'b0;
    else if (eng_tx_taken) m_empty = 1'b1;
    if (cw) m_txie = cpu_wdata[3];
    if (eng_nak_sent || !eng_enable) m_nak = 1'b0;
    else if (cw && cpu_wdata[2])     m_nak = 1'b1;
  endtask

  task automatic idle();
    cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0;
    eng_tx_taken = 0; eng_rx_valid = 0; eng_rx_byte = 0;
    eng_nak_sent = 0; eng_enable = 1;
  endtask

  // one clock: inputs already driven; update model, check outputs after edge
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R2 tx_byte", tx_byte, m_data);
    chk("R3 tx_empty", tx_empty, m_empty);
    chk("R5 irq", irq, m_txie & m_empty);
    chk("R8 nak_next", nak_next, m_nak);
  endtask

  task automatic check_read(string req, logic [1:0] a);
    cpu_wr = 0; cpu_addr = a; #1;
    chk(req, cpu_rdata, exp_read(a));
  endtask

  initial begin
    #150000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c2b));
    idle();
    rst_n = 0;
    m_data = 0; m_empty = 1; m_txie = 0; m_nak = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tx_byte", tx_byte, 0);
    chk("R1 empty", tx_empty, 1);
    chk("R1 irq", irq, 0);
    chk("R1 nak_next", nak_next, 0);
    check_read("R1 ctrl read", 2'd1);
    check_read("R1 data read", 2'd0);

    // R2 data write
    cpu_wr = 1; cpu_addr = 0; cpu_wdata = 8'hA5; step(); idle();
    check_read("R2 data read", 2'd0);
    check_read("R2 status read", 2'd2);
    check_read("R2 spare read", 2'd3);
    chk("R2 empty cleared", tx_empty, 0);

    // R5 enable interrupt while full, then take byte
    cpu_wr = 1; cpu_addr = 1; cpu_wdata = 8'h08; step(); idle();
    chk("R5 irq low when full", irq, 0);
    eng_tx_taken = 1; step(); idle();
    chk("R3 take sets empty", tx_empty, 1);
    chk("R5 irq high when empty", irq, 1);

    // R3 write beats take
    cpu_wr = 1; cpu_addr = 0; cpu_wdata = 8'h3C; eng_tx_taken = 1; step(); idle();
    chk("R3 write wins over take", tx_empty, 0);

    // R4 rx loads, empty unchanged; write beats rx
    eng_rx_valid = 1; eng_rx_byte = 8'h5A; step(); idle();
    chk("R4 rx byte loaded", tx_byte, 8'h5A);
    chk("R4 empty unchanged", tx_empty, 0);
    cpu_wr = 1; cpu_addr = 0; cpu_wdata = 8'h11; eng_rx_valid = 1; eng_rx_byte = 8'h99;
    step(); idle();
    chk("R4 write wins over rx", tx_byte, 8'h11);

    // R9 flush, reads back 0
    cpu_wr = 1; cpu_addr = 1; cpu_wdata = 8'h0A; step(); idle();
    chk("R9 flush data", tx_byte, 0);
    chk("R9 flush empty", tx_empty, 1);
    check_read("R9 flush bit reads 0", 2'd1);

    // R10 flush beats rx and take
    cpu_wr = 1; cpu_addr = 0; cpu_wdata = 8'h77; step(); idle();
    cpu_wr = 1; cpu_addr = 1; cpu_wdata = 8'h02; eng_rx_valid = 1; eng_rx_byte = 8'hEE;
    eng_tx_taken = 1; step(); idle();
    chk("R10 flush over rx data", tx_byte, 0);
    chk("R10 flush over rx empty", tx_empty, 1);

    // R6 set NAK, R7 sticky, R8 clear by sent
    cpu_wr = 1; cpu_addr = 1; cpu_wdata = 8'h04; step(); idle();
    chk("R6 nak set", nak_next, 1);
    check_read("R6 nak readback", 2'd1);
    cpu_wr = 1; cpu_addr = 1; cpu_wdata = 8'h00; step(); idle();
    chk("R7 nak sticky", nak_next, 1);
    eng_nak_sent = 1; cpu_wr = 1; cpu_addr = 1; cpu_wdata = 8'h04; step(); idle();
    chk("R8 sent beats set", nak_next, 0);
    cpu_wr = 1; cpu_addr = 1; cpu_wdata = 8'h04; step(); idle();
    eng_enable = 0; step(); idle();
    chk("R8 disable clears", nak_next, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      cpu_wr       = ($urandom % 3) == 0;
      cpu_addr     = 2'($urandom);
      cpu_wdata    = 8'($urandom);
      eng_tx_taken = ($urandom % 4) == 0;
      eng_rx_valid = ($urandom % 5) == 0;
      eng_rx_byte  = 8'($urandom);
      eng_nak_sent = ($urandom % 8) == 0;
      eng_enable   = ($urandom % 10) != 0;
      #1;
      if (!cpu_wr) chk("R2 random read", cpu_rdata, exp_read(cpu_addr));
      step();
    end
    idle();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule